// File: doc/BRIEF.md
# UART Register Front-End with Byte FIFOs and Level Interrupt

This block is the bus-facing half of a serial port. Software reaches it through a 32-bit memory-mapped interface. It sees a transmit data port, a receive data port, a control word, a status word and an interrupt level word. Bytes that software writes enter a transmit FIFO, which feeds a separate serial engine through a byte-wide valid/ready stream. Bytes from the serial engine enter a receive FIFO, which software drains by reading the receive data port. Each FIFO holds 64 bytes by default.

The serial engine also reports parity and framing errors and its busy state. The error pulses are latched into sticky status flags. The block also keeps sticky flags for two loss events: a write to a full transmit FIFO, and an arrival into a full receive FIFO. One interrupt line combines three sources: the receive FIFO at or above a programmed level, the transmit FIFO at or below a programmed level, and any latched line error. Control bits flush either FIFO and clear the sticky flags while they are held high.

Top module: `uart_front`

## Requirements
- R1: Word offsets are fixed: 0x00 transmit data, 0x04 receive data, 0x08 control, 0x0C status, 0x10 level. An access takes effect only when busAddr[1:0] is 00. Control reads back all 32 bits written. The level word keeps bits [15:0], and its upper bits read as zero. Reads of 0x00 and of unmapped offsets return zero.
- R2: A write to 0x00 queues busWdata[7:0] into the transmit FIFO. The serial engine receives the bytes in write order, one for each cycle in which txValid and txReady are both high. txValid is high exactly when the transmit count is nonzero. Status bits [14:8] hold the transmit count.
- R3: Each cycle with rxValid high stores rxByte. A read of 0x04 returns the oldest byte in bits [7:0] with zeros above it and removes that byte. Status bits [6:0] hold the receive count.
- R4: Status bit 19 is receive full, bit 20 receive empty, bit 21 transmit full and bit 22 transmit empty. After reset the status word is 0x0050_0000.
- R5: A write to 0x00 while the transmit FIFO is full discards the byte and sets sticky status bit 18.
- R6: rxValid while the receive FIFO is full discards the byte and sets sticky status bit 24.
- R7: A read of 0x04 while the receive FIFO is empty returns zero and leaves the receive count unchanged.
- R8: A one-cycle pulse on parityErr sets sticky status bit 16. A pulse on frameErr sets sticky status bit 17.
- R9: While control bit 24 is 1, status bits 16, 17, 18 and 24 are held at zero.
- R10: While control bit 22 is 1, the transmit FIFO is empty and ignores writes. While control bit 23 is 1, the same holds for the receive FIFO and rxValid, and no overflow is flagged.
- R11: irq is high when control bit 27 is 1 and the receive count is at least level bits [7:0].
- R12: irq is high when control bit 28 is 1 and the transmit count is at most level bits [15:8].
- R13: irq is high when any of status bits 16, 17 or 24 is set and control bit 30 is 0. With none of the three sources active, irq is low.
- R14: Status bit 25 reflects the txBusy input and bit 26 reflects rxBusy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | 5 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the access |
| txByte | output | 8 | Byte offered to serial engine |
| txValid | output | 1 | Transmit byte available |
| txReady | input | 1 | Serial engine accepts the byte |
| rxByte | input | 8 | Byte from serial engine |
| rxValid | input | 1 | Receive byte strobe |
| parityErr | input | 1 | Parity error pulse |
| frameErr | input | 1 | Framing error pulse |
| txBusy | input | 1 | Serial engine transmitting |
| rxBusy | input | 1 | Serial engine receiving |
| irq | output | 1 | Combined interrupt |

## Verification
The bench fills the transmit FIFO to 64 entries and writes once more. A design that wraps its pointers would then send a stray byte or lose the oldest one, and the transmit scoreboard catches this. It pushes 65 bytes into the receive FIFO and reads an empty FIFO. An off-by-one in the full test would keep the 65th byte, and a careless read pop would drive the count negative. Both show up as wrong data or wrong counts. The bench steps the receive and transmit counts across their interrupt levels, so a comparison with the wrong sense or a strict inequality makes irq change one byte early or late. It also holds each flush bit while traffic arrives, which exposes flushes that act only on the first edge.

// File: rtl/uart_front_pkg.sv
`timescale 1ns/1ps
package uart_front_pkg;
  // word offsets (busAddr[4:2])
  localparam logic [2:0] OFF_TXDATA = 3'd0;
  localparam logic [2:0] OFF_RXDATA = 3'd1;
  localparam logic [2:0] OFF_CTRL   = 3'd2;
  localparam logic [2:0] OFF_STATUS = 3'd3;
  localparam logic [2:0] OFF_LEVEL  = 3'd4;

  // control bit positions
  localparam int C_TXFLUSH = 22;
  localparam int C_RXFLUSH = 23;
  localparam int C_ERRCLR  = 24;
  localparam int C_RXIEN   = 27;
  localparam int C_TXIEN   = 28;
  localparam int C_ERRMASK = 30;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
    logic errClear;
  } frontStrobes_t;

  typedef struct packed {
    logic overflow;
    logic wroteFull;
    logic frame;
    logic parity;
  } frontFlags_t;
endpackage

// File: rtl/uart_front_fifo.sv
`timescale 1ns/1ps
module uart_front_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end
endmodule

// File: rtl/uart_front_dp.sv
`timescale 1ns/1ps
module uart_front_dp
  import uart_front_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  frontStrobes_t strobes,
  input  logic [7:0]    wrByte,
  output logic [7:0]    txByte,
  output logic          txValid,
  input  logic          txReady,
  input  logic [7:0]    rxByte,
  input  logic          rxValid,
  input  logic          parityErr,
  input  logic          frameErr,
  output logic [7:0]    rxHead,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic          txFull,
  output logic          txEmpty,
  output logic          rxFull,
  output logic          rxEmpty,
  output frontFlags_t   flags
);
  assign txValid = !txEmpty;

  uart_front_fifo #(.WIDTH(8), .DEPTH(DEPTH), .CW(CW)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(strobes.txFlush),
    .push(strobes.txPush), .wrData(wrByte), .pop(txReady),
    .rdData(txByte), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  uart_front_fifo #(.WIDTH(8), .DEPTH(DEPTH), .CW(CW)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strobes.rxFlush),
    .push(rxValid), .wrData(rxByte), .pop(strobes.rxPop),
    .rdData(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  // sticky error flags; a held clear dominates any new event
  always_ff @(posedge clk) begin
    if (!rstN || strobes.errClear) begin
      flags <= '0;
    end else begin
      if (parityErr) flags.parity <= 1'b1;
      if (frameErr)  flags.frame  <= 1'b1;
      if (strobes.txPush && txFull && !strobes.txFlush) flags.wroteFull <= 1'b1;
      if (rxValid && rxFull && !strobes.rxFlush)         flags.overflow  <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_front_ctrl.sv
`timescale 1ns/1ps
module uart_front_ctrl
  import uart_front_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busSel,
  input  logic          busWrite,
  input  logic [4:0]    busAddr,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  output frontStrobes_t strobes,
  output logic [31:0]   ctrlWord,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic          txFull,
  input  logic          txEmpty,
  input  logic          rxFull,
  input  logic          rxEmpty,
  input  logic [7:0]    rxHead,
  input  frontFlags_t   flags,
  input  logic          txBusy,
  input  logic          rxBusy,
  output logic          irq
);
  logic [15:0] levelWord;
  logic        hit, wrHit, rdHit;
  logic [2:0]  idx;
  logic [31:0] statusWord;
  logic        rxIrq, txIrq, errIrq;

  assign idx   = busAddr[4:2];
  assign hit   = busSel && (busAddr[1:0] == 2'b00);
  assign wrHit = hit && busWrite;
  assign rdHit = hit && !busWrite;

  assign strobes.txPush   = wrHit && (idx == OFF_TXDATA);
  assign strobes.rxPop    = rdHit && (idx == OFF_RXDATA);
  assign strobes.txFlush  = ctrlWord[C_TXFLUSH];
  assign strobes.rxFlush  = ctrlWord[C_RXFLUSH];
  assign strobes.errClear = ctrlWord[C_ERRCLR];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord  <= '0;
      levelWord <= '0;
    end else if (wrHit) begin
      if (idx == OFF_CTRL)  ctrlWord  <= busWdata;
      if (idx == OFF_LEVEL) levelWord <= busWdata[15:0];
    end
  end

  always_comb begin
    statusWord        = '0;
    statusWord[6:0]   = 7'(rxCount);
    statusWord[14:8]  = 7'(txCount);
    statusWord[16]    = flags.parity;
    statusWord[17]    = flags.frame;
    statusWord[18]    = flags.wroteFull;
    statusWord[19]    = rxFull;
    statusWord[20]    = rxEmpty;
    statusWord[21]    = txFull;
    statusWord[22]    = txEmpty;
    statusWord[24]    = flags.overflow;
    statusWord[25]    = txBusy;
    statusWord[26]    = rxBusy;
  end

  always_comb begin
    busRdata = '0;
    if (rdHit) begin
      case (idx)
        OFF_RXDATA: busRdata = {24'b0, rxEmpty ? 8'h00 : rxHead};
        OFF_CTRL:   busRdata = ctrlWord;
        OFF_STATUS: busRdata = statusWord;
        OFF_LEVEL:  busRdata = {16'b0, levelWord};
        default:    busRdata = '0;
      endcase
    end
  end

  assign rxIrq  = ctrlWord[C_RXIEN] && (8'(rxCount) >= levelWord[7:0]);
  assign txIrq  = ctrlWord[C_TXIEN] && (8'(txCount) <= levelWord[15:8]);
  assign errIrq = !ctrlWord[C_ERRMASK] && (flags.parity || flags.frame || flags.overflow);
  assign irq    = rxIrq || txIrq || errIrq;
endmodule

// File: rtl/uart_front.sv
`timescale 1ns/1ps
module uart_front
  import uart_front_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic [7:0]  txByte,
  output logic        txValid,
  input  logic        txReady,
  input  logic [7:0]  rxByte,
  input  logic        rxValid,
  input  logic        parityErr,
  input  logic        frameErr,
  input  logic        txBusy,
  input  logic        rxBusy,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  frontStrobes_t strobes;
  frontFlags_t   flags;
  logic [31:0]   ctrlWord;
  logic [CW-1:0] txCount, rxCount;
  logic          txFull, txEmpty, rxFull, rxEmpty;
  logic [7:0]    rxHead;

  uart_front_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .strobes(strobes), .ctrlWord(ctrlWord),
    .txCount(txCount), .rxCount(rxCount), .txFull(txFull), .txEmpty(txEmpty),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .rxHead(rxHead), .flags(flags),
    .txBusy(txBusy), .rxBusy(rxBusy), .irq(irq)
  );

  uart_front_dp #(.DEPTH(DEPTH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrByte(busWdata[7:0]),
    .txByte(txByte), .txValid(txValid), .txReady(txReady),
    .rxByte(rxByte), .rxValid(rxValid), .parityErr(parityErr), .frameErr(frameErr),
    .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .flags(flags)
  );
endmodule

// File: rtl/uart_front_checker.sv
`timescale 1ns/1ps
module uart_front_checker
  import uart_front_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic          busSel,
  input logic          busWrite,
  input logic [4:0]    busAddr,
  input logic [31:0]   busRdata,
  input logic          txValid,
  input logic          txReady,
  input logic          rxValid,
  input logic          irq,
  input logic [31:0]   ctrlWord,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount,
  input frontFlags_t   flags
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic txWr, rxRd, ctrlWr;
  assign txWr   = busSel && busWrite && (busAddr == 5'h00);
  assign rxRd   = busSel && !busWrite && (busAddr == 5'h04);
  assign ctrlWr = busSel && busWrite && (busAddr == 5'h08);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= FULL_CNT && rxCount <= FULL_CNT);

  a_r2_valid_tracks_count: assert property (@(posedge clk) disable iff (!rstN)
    txValid == (txCount != '0));

  a_r5_full_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (txWr && txCount == FULL_CNT && !(txValid && txReady) && !ctrlWord[C_TXFLUSH])
    |=> txCount == FULL_CNT);

  a_r5_full_write_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (txWr && txCount == FULL_CNT && !ctrlWord[C_TXFLUSH] && !ctrlWord[C_ERRCLR])
    |=> flags.wroteFull);

  a_r6_overflow_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxCount == FULL_CNT && !ctrlWord[C_RXFLUSH] && !ctrlWord[C_ERRCLR])
    |=> flags.overflow);

  a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rxRd && rxCount == '0) |-> busRdata == 32'h0);

  a_r7_empty_read_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (rxRd && rxCount == '0 && !rxValid) |=> rxCount == '0);

  a_r9_clear_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[C_ERRCLR] && !ctrlWr) |=> flags == '0);

  a_r13_quiet_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[C_ERRMASK] && !ctrlWord[C_RXIEN] && !ctrlWord[C_TXIEN]) |-> !irq);
endmodule

bind uart_front uart_front_checker #(.DEPTH(DEPTH), .CW(CW)) u_check (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
  .busRdata(busRdata), .txValid(txValid), .txReady(txReady), .rxValid(rxValid),
  .irq(irq), .ctrlWord(ctrlWord), .txCount(txCount), .rxCount(rxCount), .flags(flags)
);

// File: tb/test_uart_front.sv
`timescale 1ns/1ps
module test_uart_front;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0] txByte;
  logic txValid;
  logic txReady = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxValid = 1'b0, parityErr = 1'b0, frameErr = 1'b0;
  logic txBusy = 1'b0, rxBusy = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] txModel[$];
  logic [7:0] rxModel[$];
  bit txHold = 0, rxHold = 0;

  always #2.5 clk = ~clk;

  uart_front #(.DEPTH(DEPTH)) i_uart_front (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txByte(txByte), .txValid(txValid),
    .txReady(txReady), .rxByte(rxByte), .rxValid(rxValid), .parityErr(parityErr),
    .frameErr(frameErr), .txBusy(txBusy), .rxBusy(rxBusy), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  // driver: queue expected transmit bytes
  task automatic txWrite(input logic [31:0] d);
    if (!txHold && txModel.size() < DEPTH) txModel.push_back(d[7:0]);
    busWr(5'h00, d);
  endtask

  task automatic rxSend(input logic [7:0] b);
    if (!rxHold && rxModel.size() < DEPTH) rxModel.push_back(b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic rxRead(input string req);
    logic [31:0] d;
    logic [7:0] e;
    e = (rxModel.size() > 0) ? rxModel.pop_front() : 8'h00;
    busRd(5'h04, d);
    check(req, d, {24'b0, e});
  endtask

  task automatic statusField(input string req, input logic [31:0] mask, input logic [31:0] exp);
    logic [31:0] d;
    busRd(5'h0C, d);
    check(req, d & mask, exp);
  endtask

  task automatic drainTx();
    @(negedge clk); txReady = 1'b1;
    repeat (DEPTH + 6) @(negedge clk);
    txReady = 1'b0;
    @(negedge clk);
    check("R2 scoreboard drained", txModel.size(), 0);
  endtask

  task automatic irqIs(input string req, input logic exp);
    @(negedge clk); #1;
    check(req, irq, exp);
  endtask

  // monitor: compare each transmitted byte against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rstN && txValid && txReady) begin
        if (txModel.size() == 0) check("R2 unexpected byte", txByte, 8'hxx);
        else check("R2 transmit order", txByte, txModel.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R4: reset state
    statusField("R4 reset status", 32'hFFFF_FFFF, 32'h0050_0000);
    irqIs("R13 irq low after reset", 1'b0);
    check("R2 txValid low after reset", txValid, 1'b0);

    // R1: map, readback, alignment
    busWr(5'h08, 32'h4000_0000);
    busRd(5'h08, d); check("R1 control readback", d, 32'h4000_0000);
    busWr(5'h09, 32'hFFFF_FFFF);
    busRd(5'h08, d); check("R1 misaligned write ignored", d, 32'h4000_0000);
    busWr(5'h10, 32'hFFFF_1234);
    busRd(5'h10, d); check("R1 level upper bits zero", d, 32'h0000_1234);
    busRd(5'h00, d); check("R1 tx port reads zero", d, 32'h0);
    busRd(5'h14, d); check("R1 unmapped reads zero", d, 32'h0);

    // R2: transmit path, upper data bits ignored
    txWrite(32'hABCD_0011); txWrite(32'h0000_0022); txWrite(32'hFF00_0033);
    statusField("R2 tx count 3", 32'h0000_7F00, 32'h0000_0300);
    drainTx();
    statusField("R4 tx empty after drain", 32'h0060_7F00, 32'h0040_0000);

    // R5: fill, then overfill
    for (int i = 0; i < DEPTH; i++) txWrite(32'h0000_0080 + i);
    statusField("R4 tx full", 32'h0060_7F00, 32'h0020_4000);
    statusField("R5 no flag before overfill", 32'h0004_0000, 32'h0);
    txWrite(32'h0000_005A);
    statusField("R5 overfill dropped and flagged", 32'h0004_7F00, 32'h0004_4000);
    drainTx();

    // R7: empty read
    rxRead("R7 empty read zero");
    statusField("R7 count unchanged", 32'h0010_007F, 32'h0010_0000);

    // R3: receive path
    rxSend(8'hC1); rxSend(8'hC2); rxSend(8'hC3);
    statusField("R3 rx count 3", 32'h0000_007F, 32'h0000_0003);
    rxRead("R3 oldest first"); rxRead("R3 second"); rxRead("R3 third");

    // R6: overflow
    for (int i = 0; i < DEPTH + 1; i++) rxSend(8'(8'h20 + i));
    statusField("R6 full and overflow", 32'h0118_007F, 32'h0108_0040);
    for (int i = 0; i < DEPTH; i++) rxRead("R6 stored byte order");
    statusField("R4 rx empty after reads", 32'h0018_007F, 32'h0010_0000);

    // R9: clear sticky flags
    busWr(5'h08, 32'h4100_0000);
    busWr(5'h08, 32'h4000_0000);
    statusField("R9 sticky flags cleared", 32'h0107_0000, 32'h0);

    // R8 / R13: line errors
    @(negedge clk); parityErr = 1'b1; @(negedge clk); parityErr = 1'b0;
    statusField("R8 parity latched", 32'h0003_0000, 32'h0001_0000);
    irqIs("R13 masked error", 1'b0);
    busWr(5'h08, 32'h0000_0000);
    irqIs("R13 unmasked error", 1'b1);
    @(negedge clk); frameErr = 1'b1; @(negedge clk); frameErr = 1'b0;
    statusField("R8 frame latched", 32'h0003_0000, 32'h0003_0000);
    busWr(5'h08, 32'h0100_0000);
    busWr(5'h08, 32'h0000_0000);
    statusField("R9 errors cleared", 32'h0003_0000, 32'h0);
    irqIs("R13 no source irq low", 1'b0);

    // R11: receive level
    busWr(5'h10, 32'h0000_0002);
    busWr(5'h08, 32'h4800_0000);
    irqIs("R11 below level", 1'b0);
    rxSend(8'h51);
    irqIs("R11 one below level", 1'b0);
    rxSend(8'h52);
    irqIs("R11 at level", 1'b1);
    rxRead("R11 read");
    irqIs("R11 back below level", 1'b0);
    rxRead("R11 read last");

    // R12: transmit level
    busWr(5'h10, 32'h0000_0100);
    busWr(5'h08, 32'h5000_0000);
    irqIs("R12 empty below level", 1'b1);
    txWrite(32'h0000_0061);
    irqIs("R12 at level", 1'b1);
    txWrite(32'h0000_0062);
    irqIs("R12 above level", 1'b0);

    // R10: flushes held
    busWr(5'h08, 32'h4040_0000);
    txHold = 1; txModel.delete();
    txWrite(32'h0000_0077);
    statusField("R10 tx flushed and blocked", 32'h0044_7F00, 32'h0040_0000);
    busWr(5'h08, 32'h4000_0000);
    txHold = 0;
    check("R10 txValid low after flush", txValid, 1'b0);
    rxSend(8'h91); rxSend(8'h92);
    busWr(5'h08, 32'h4080_0000);
    rxHold = 1; rxModel.delete();
    rxSend(8'h93);
    statusField("R10 rx flushed and blocked", 32'h0110_007F, 32'h0010_0000);
    busWr(5'h08, 32'h4000_0000);
    rxHold = 0;
    rxRead("R10 rx empty after release");

    // R14: busy reflection
    @(negedge clk); txBusy = 1'b1;
    statusField("R14 tx busy", 32'h0600_0000, 32'h0200_0000);
    @(negedge clk); txBusy = 1'b0; rxBusy = 1'b1;
    statusField("R14 rx busy", 32'h0600_0000, 32'h0400_0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule